// File: doc/BRIEF.md
# Configuration Register Slave on a Two-Wire Bus

This block connects a two-wire serial management bus (SMBus / I2C signalling) to a small bank of 8-bit configuration registers. A host can update or inspect the registers with four transfer types: single-byte write, single-byte read, sequential (block) write and sequential (block) read. The top bit of the command byte chooses the transfer type. In single-byte transfers the remaining seven command bits give the register offset. Block transfers always begin at offset 0.

Both bus lines are sampled with the system clock through two-stage synchronisers. Start and stop conditions are SDA edges seen while SCL is high. The slave drives SDA only by pulling it low, through an output-enable. It does not stretch the clock. The whole register bank is also presented on a flat parallel output, so the rest of the chip can use the settings directly. A block read first returns a byte count, which is the value held in the count register at offset 12. It then returns data from ascending offsets. Data bytes beyond that count read as 0xFF.

Top module: `smbus_cfg_slave`

## Requirements
- R1: The slave acknowledges (pulls SDA low in the ninth bit) only the address byte 0xD2 for writes or 0xD3 for reads (7-bit address 1101001). Any other address is not acknowledged, and the slave leaves SDA released and the registers untouched until the next start condition.
- R2: Byte write: the host sends the address, then a command byte with bit 7 = 1 and bits 6:0 = offset, then one data byte (MSB first). The register at that offset takes the data byte, and all three bytes are acknowledged.
- R3: Byte read: the host sends the address, the command byte with bit 7 = 1 and the offset, a repeated start, and 0xD3. The slave returns the register at that offset MSB first.
- R4: Block write: the host sends a command byte of 0x00, then a byte-count byte, then data bytes that are stored at offsets 0, 1, 2, … in order. A stop after any complete byte ends the transfer, and the bytes already received are kept.
- R5: Block read: the host sends a command byte of 0x00, a repeated start, and 0xD3. The slave first returns the value of the count register (offset 12). Data byte i (counting from 0) is then register i when i is less than that count, and 0xFF otherwise.
- R6: Reset loads the defaults: offset 7 = 0x24, offset 8 = 0x81, offset 12 = 0x0F, and every other offset = 0x00.
- R7: Offsets 7 and 8 are read-only identification bytes. Writes to them are acknowledged and discarded.
- R8: Offsets at or above the register count (16) are acknowledged on write and discarded. They read as 0xFF.
- R9: When the host does not acknowledge a byte the slave sent, the slave stops driving. It keeps SDA released until the next start or stop condition.
- R10: cfg_o always carries register k on bits 8k+7 down to 8k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; oversamples the bus lines |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 = pull SDA low (acknowledge or a zero data bit) |
| cfg_o | output | NREGS*8 | Flat image of the register bank |

## Verification
A corrupted offset pointer or transfer mode shows up at the ports in one of two ways. The next read byte is wrong, or cfg_o changes at a byte it should not touch. The wrong cfg_o byte appears within about three system clocks after the SCL falling edge that closes the data byte. A wrong protocol phase makes the slave drive SDA when the host expects a released line, for example during address bits, after a NACK, or after an address mismatch. The bench sees this at the next SCL high phase. A bad count register turns the tail of a block read into 0xFF one byte early or one byte late.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

  typedef enum logic [2:0] {
    PH_IDLE, PH_RX, PH_RACK, PH_TX, PH_TACK, PH_IGNORE
  } phase_e;

  typedef enum logic [1:0] {
    K_ADDR, K_CMD, K_CNT, K_DATA
  } rxkind_e;

  // upper seven bits of the address byte against the configured address
  function automatic logic addr_hit(input logic [7:0] b, input logic [6:0] a);
    return b[7:1] == a;
  endfunction

  // single-byte commands carry an offset, block commands start at zero
  function automatic logic [7:0] start_ptr(input logic [7:0] c);
    return c[7] ? {1'b0, c[6:0]} : 8'd0;
  endfunction

  // byte to send next: count first in a block read, 0xFF past the limit
  function automatic logic [7:0] pick_tx(input logic blk, input logic first,
                                         input logic [7:0] ptr, input logic [7:0] cnt,
                                         input logic [7:0] rd);
    if (blk && first)      return cnt;
    else if (blk && ptr >= cnt) return 8'hFF;
    else                   return rd;
  endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic ev_start,
  output logic ev_stop,
  output logic ev_rise,
  output logic ev_fall
);
  logic scl_m, scl_s, scl_q, sda_m, sda_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {scl_m, scl_s, scl_q} <= 3'b111;
      {sda_m, sda_s, sda_q} <= 3'b111;
    end else begin
      scl_m <= scl_i;  scl_s <= scl_m;  scl_q <= scl_s;
      sda_m <= sda_i;  sda_s <= sda_m;  sda_q <= sda_s;
    end
  end

  assign ev_start = scl_s & scl_q & sda_q & ~sda_s;
  assign ev_stop  = scl_s & scl_q & ~sda_q & sda_s;
  assign ev_rise  = scl_s & ~scl_q;
  assign ev_fall  = ~scl_s & scl_q;
endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank #(
  parameter int          NREGS   = 16,
  parameter int          CNT_IDX = 12,
  parameter int          RO_A    = 7,
  parameter int          RO_B    = 8,
  parameter logic [7:0]  DEF_A   = 8'h24,
  parameter logic [7:0]  DEF_B   = 8'h81,
  parameter logic [7:0]  DEF_CNT = 8'd15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [7:0]         wr_idx,
  input  logic [7:0]         wr_data,
  input  logic [7:0]         rd_idx,
  output logic [7:0]         rd_data,
  output logic [7:0]         cnt_o,
  output logic [NREGS*8-1:0] regs_o
);
  localparam int         IW  = $clog2(NREGS);
  localparam logic [8:0] NR9 = 9'(NREGS);

  function automatic logic [7:0] reg_default(input int i);
    if (i == RO_A)    return DEF_A;
    if (i == RO_B)    return DEF_B;
    if (i == CNT_IDX) return DEF_CNT;
    return 8'h00;
  endfunction

  function automatic logic writable(input int i);
    return (i != RO_A) && (i != RO_B);
  endfunction

  logic [7:0] r [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        r[g] <= reg_default(g);
      else if (wr_en && wr_idx == 8'(g) && writable(g))
        r[g] <= wr_data;
    end
    assign regs_o[g*8 +: 8] = r[g];
  end

  assign rd_data = ({1'b0, rd_idx} < NR9) ? r[rd_idx[IW-1:0]] : 8'hFF;
  assign cnt_o   = r[CNT_IDX];
endmodule

// File: rtl/smb_link_fsm.sv
module smb_link_fsm
  import smb_cfg_pkg::*;
#(
  parameter logic [6:0] ADDR7 = 7'h69
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_start,
  input  logic       ev_stop,
  input  logic       ev_rise,
  input  logic       ev_fall,
  input  logic       sda_s,
  input  logic [7:0] rd_data,
  input  logic [7:0] cnt_val,
  output logic       sda_oe,
  output logic       wr_fire,
  output logic [7:0] wr_idx,
  output logic [7:0] wr_data,
  output logic [7:0] rd_idx,
  output logic       ignoring,
  output logic       slave_slot
);
  phase_e     phase;
  rxkind_e    kind;
  logic [3:0] bitcnt;
  logic [7:0] sh, ptr;
  logic       blk, first, tx_after, host_ack;
  logic [7:0] tx_byte;

  assign rd_idx     = ptr;
  assign tx_byte    = pick_tx(blk, first, ptr, cnt_val, rd_data);
  assign ignoring   = (phase == PH_IGNORE);
  assign slave_slot = (phase == PH_RACK) || (phase == PH_TX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;  kind <= K_ADDR;  bitcnt <= '0;  sh <= '0;
      ptr <= '0;  blk <= 1'b0;  first <= 1'b0;  tx_after <= 1'b0;
      host_ack <= 1'b0;  sda_oe <= 1'b0;  wr_fire <= 1'b0;
      wr_idx <= '0;  wr_data <= '0;
    end else begin
      wr_fire <= 1'b0;
      if (ev_start) begin
        phase <= PH_RX;  kind <= K_ADDR;  bitcnt <= '0;  sda_oe <= 1'b0;
      end else if (ev_stop) begin
        phase <= PH_IDLE;  sda_oe <= 1'b0;
      end else begin
        case (phase)
          PH_RX: begin
            if (ev_rise && bitcnt < 4'd8) begin
              sh     <= {sh[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (ev_fall && bitcnt == 4'd8) begin
              bitcnt   <= '0;
              phase    <= PH_RACK;
              sda_oe   <= 1'b1;
              tx_after <= 1'b0;
              case (kind)
                K_ADDR: begin
                  if (!addr_hit(sh, ADDR7)) begin
                    phase  <= PH_IGNORE;
                    sda_oe <= 1'b0;
                  end else if (sh[0]) begin
                    tx_after <= 1'b1;
                    first    <= blk;
                  end else begin
                    kind <= K_CMD;
                  end
                end
                K_CMD: begin
                  blk  <= ~sh[7];
                  ptr  <= start_ptr(sh);
                  kind <= sh[7] ? K_DATA : K_CNT;
                end
                K_CNT:   kind <= K_DATA;
                default: begin
                  wr_fire <= 1'b1;
                  wr_idx  <= ptr;
                  wr_data <= sh;
                  ptr     <= ptr + 8'd1;
                end
              endcase
            end
          end
          PH_RACK: begin
            if (ev_fall) begin
              if (tx_after) begin
                sh     <= tx_byte;
                sda_oe <= ~tx_byte[7];
                bitcnt <= '0;
                first  <= 1'b0;
                if (!(blk && first)) ptr <= ptr + 8'd1;
                phase  <= PH_TX;
              end else begin
                sda_oe <= 1'b0;
                phase  <= PH_RX;
              end
            end
          end
          PH_TX: begin
            if (ev_fall) begin
              if (bitcnt == 4'd7) begin
                sda_oe <= 1'b0;
                bitcnt <= '0;
                phase  <= PH_TACK;
              end else begin
                sh     <= {sh[6:0], 1'b0};
                sda_oe <= ~sh[6];
                bitcnt <= bitcnt + 4'd1;
              end
            end
          end
          PH_TACK: begin
            if (ev_rise) host_ack <= ~sda_s;
            else if (ev_fall) begin
              if (host_ack) begin
                sh     <= tx_byte;
                sda_oe <= ~tx_byte[7];
                bitcnt <= '0;
                first  <= 1'b0;
                if (!(blk && first)) ptr <= ptr + 8'd1;
                phase  <= PH_TX;
              end else begin
                phase <= PH_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/smbus_cfg_slave.sv
module smbus_cfg_slave #(
  parameter int          NREGS   = 16,
  parameter logic [6:0]  ADDR7   = 7'h69,
  parameter int          CNT_IDX = 12,
  parameter int          RO_A    = 7,
  parameter int          RO_B    = 8,
  parameter logic [7:0]  DEF_A   = 8'h24,
  parameter logic [7:0]  DEF_B   = 8'h81,
  parameter logic [7:0]  DEF_CNT = 8'd15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  output logic [NREGS*8-1:0] cfg_o
);
  logic       sda_s, ev_start, ev_stop, ev_rise, ev_fall;
  logic       wr_fire, ignoring, slave_slot;
  logic [7:0] wr_idx, wr_data, rd_idx, rd_data, cnt_val;

  smb_line_sync u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
    .ev_start(ev_start), .ev_stop(ev_stop), .ev_rise(ev_rise), .ev_fall(ev_fall)
  );

  smb_link_fsm #(.ADDR7(ADDR7)) u_fsm (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
    .ev_rise(ev_rise), .ev_fall(ev_fall), .sda_s(sda_s),
    .rd_data(rd_data), .cnt_val(cnt_val), .sda_oe(sda_oe),
    .wr_fire(wr_fire), .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx),
    .ignoring(ignoring), .slave_slot(slave_slot)
  );

  smb_reg_bank #(
    .NREGS(NREGS), .CNT_IDX(CNT_IDX), .RO_A(RO_A), .RO_B(RO_B),
    .DEF_A(DEF_A), .DEF_B(DEF_B), .DEF_CNT(DEF_CNT)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_fire), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
    .cnt_o(cnt_val), .regs_o(cfg_o)
  );
endmodule

// File: rtl/smbus_cfg_slave_chk.sv
module smbus_cfg_slave_chk #(
  parameter int NREGS = 16,
  parameter int RO_A  = 7,
  parameter int RO_B  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ev_start,
  input logic               ev_stop,
  input logic               ev_rise,
  input logic               ev_fall,
  input logic               sda_oe,
  input logic               wr_fire,
  input logic               ignoring,
  input logic               slave_slot,
  input logic [NREGS*8-1:0] cfg_o
);
  // R9: the data line output moves only in response to a bus event
  a_r9_oe_moves_on_events: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_start || ev_stop || ev_rise || ev_fall) |=> $stable(sda_oe));

  // R1: a slave that lost address match stays off the line
  a_r1_silent_when_ignoring: assert property (@(posedge clk) disable iff (!rst_n)
    ignoring |-> !sda_oe);

  // R3: drive only in an acknowledge slot or while sending a byte
  a_r3_drive_in_slave_slot: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> slave_slot);

  // R7: identification bytes never change after reset
  a_r7_ids_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(cfg_o[RO_A*8 +: 8]) && $stable(cfg_o[RO_B*8 +: 8]));

  // R2: the register image changes only right after a write strobe
  a_r2_change_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_o) |-> $past(wr_fire));

  // R4: a write strobe follows the SCL fall that closes a data byte
  a_r4_write_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> $past(ev_fall));
endmodule

bind smbus_cfg_slave smbus_cfg_slave_chk #(.NREGS(NREGS), .RO_A(RO_A), .RO_B(RO_B)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
  .ev_rise(ev_rise), .ev_fall(ev_fall), .sda_oe(sda_oe), .wr_fire(wr_fire),
  .ignoring(ignoring), .slave_slot(slave_slot), .cfg_o(cfg_o)
);

// File: tb/smbus_cfg_slave_test.sv
module smbus_cfg_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;
  localparam int NR = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_drv = 1'b1;
  logic sda_drv = 1'b1;
  logic sda_oe;
  logic [NR*8-1:0] cfg_o;
  wire  sda_line = sda_drv & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  smbus_cfg_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_line),
    .sda_oe(sda_oe), .cfg_o(cfg_o)
  );

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  logic [7:0] model [NR];
  logic hold = 1'b1;
  logic must_release = 1'b0;
  logic silent = 1'b0;
  logic pend_v = 1'b0;
  int   pend_i = 0;
  logic [7:0] pend_d = 8'h00;

  function automatic logic is_ro(input int i);
    return i == 7 || i == 8;
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  // per-clock comparison against the behavioural model
  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      miscompares++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
    if (rst_n) begin
      if (!hold)
        for (int k = 0; k < NR; k++)
          check(cfg_o[k*8 +: 8] === model[k], "R10", cfg_o[k*8 +: 8], model[k]);
      if (must_release) check(sda_oe === 1'b0, "R1/R9 line released", sda_oe, 0);
    end
  end

  task automatic half_bit();
    repeat (HALF) @(posedge clk);
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; half_bit();
    scl_drv = 1'b1; half_bit();
    sda_drv = 1'b0; half_bit();
    scl_drv = 1'b0;
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; half_bit();
    scl_drv = 1'b1; half_bit();
    sda_drv = 1'b1; half_bit();
  endtask

  task automatic write_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; half_bit();
      scl_drv = 1'b1; must_release = 1'b1; half_bit();
      scl_drv = 1'b0;
    end
    hold = 1'b1; must_release = silent;
    sda_drv = 1'b1; half_bit();
    scl_drv = 1'b1;
    repeat (HALF/2) @(posedge clk);
    ack = ~sda_line;
    if (pend_v) begin model[pend_i] = pend_d; pend_v = 1'b0; end
    hold = 1'b0;
    repeat (HALF/2) @(posedge clk);
    scl_drv = 1'b0;
  endtask

  task automatic read_byte(input logic give_ack, output logic [7:0] b);
    must_release = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      half_bit();
      scl_drv = 1'b1;
      repeat (HALF/2) @(posedge clk);
      b[i] = sda_line;
      repeat (HALF/2) @(posedge clk);
      scl_drv = 1'b0;
    end
    sda_drv = give_ack ? 1'b0 : 1'b1; half_bit();
    scl_drv = 1'b1; half_bit();
    scl_drv = 1'b0;
    sda_drv = 1'b1;
  endtask

  function automatic logic [7:0] exp_rd(input int off);
    return (off < NR) ? model[off] : 8'hFF;
  endfunction

  task automatic byte_write(input int off, input logic [7:0] val, input string req);
    logic a;
    bus_start();
    write_byte(8'hD2, a); check(a, "R1 address ack", a, 1);
    write_byte(8'h80 | 8'(off), a); check(a, req, a, 1);
    if (off < NR && !is_ro(off)) begin pend_v = 1'b1; pend_i = off; pend_d = val; end
    write_byte(val, a); check(a, req, a, 1);
    bus_stop();
  endtask

  task automatic byte_read(input int off, input string req);
    logic a; logic [7:0] b;
    bus_start();
    write_byte(8'hD2, a); check(a, "R1 address ack", a, 1);
    write_byte(8'h80 | 8'(off), a); check(a, req, a, 1);
    bus_start();
    write_byte(8'hD3, a); check(a, "R1 read address ack", a, 1);
    read_byte(1'b0, b);
    check(b === exp_rd(off), req, b, exp_rd(off));
    bus_stop();
  endtask

  task automatic block_write(input int n, input logic [7:0] base);
    logic a;
    bus_start();
    write_byte(8'hD2, a); check(a, "R1 address ack", a, 1);
    write_byte(8'h00, a); check(a, "R4 command ack", a, 1);
    write_byte(8'(n), a); check(a, "R4 count ack", a, 1);
    for (int i = 0; i < n; i++) begin
      if (i < NR && !is_ro(i)) begin pend_v = 1'b1; pend_i = i; pend_d = base + 8'(i * 7); end
      write_byte(base + 8'(i * 7), a); check(a, "R4 data ack", a, 1);
    end
    bus_stop();
  endtask

  task automatic block_read(input int nd, input logic nack_then_extra);
    logic a; logic [7:0] b;
    int lim;
    bus_start();
    write_byte(8'hD2, a); check(a, "R1 address ack", a, 1);
    write_byte(8'h00, a); check(a, "R5 command ack", a, 1);
    bus_start();
    write_byte(8'hD3, a); check(a, "R1 read address ack", a, 1);
    lim = int'(model[12]);
    read_byte(nd > 0, b); check(b === model[12], "R5 count byte", b, model[12]);
    for (int i = 0; i < nd; i++) begin
      logic [7:0] e;
      e = (i < lim) ? exp_rd(i) : 8'hFF;
      read_byte(i != nd - 1, b);
      check(b === e, (i >= NR) ? "R8 block read past bank" : "R5 block data", b, e);
    end
    if (nack_then_extra) begin
      silent = 1'b1;
      read_byte(1'b0, b); check(b === 8'hFF, "R9 released after NACK", b, 8'hFF);
      silent = 1'b0;
    end
    bus_stop();
  endtask

  initial begin
    logic a;
    for (int k = 0; k < NR; k++) model[k] = 8'h00;
    model[7] = 8'h24; model[8] = 8'h81; model[12] = 8'h0F;
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    for (int k = 0; k < NR; k++)
      check(cfg_o[k*8 +: 8] === model[k], "R6 reset default", cfg_o[k*8 +: 8], model[k]);
    check(sda_oe === 1'b0, "R6 line released at reset", sda_oe, 0);
    hold = 1'b0;

    byte_write(3, 8'hA5, "R2 byte write");
    byte_read(3, "R3 byte read");
    byte_write(9, 8'h3C, "R2 byte write");
    byte_read(9, "R3 byte read");
    byte_read(12, "R3 count default read");

    byte_write(7, 8'h00, "R7 read-only write ack");
    byte_read(7, "R7 read-only unchanged");
    byte_write(8, 8'hFF, "R7 read-only write ack");
    byte_read(8, "R7 read-only unchanged");

    byte_write(40, 8'h77, "R8 out-of-range write ack");
    byte_read(40, "R8 out-of-range reads FF");

    // R1: foreign address, slave stays silent for the rest of the frame
    bus_start();
    silent = 1'b1;
    write_byte(8'hA0, a); check(!a, "R1 foreign address NACK", a, 0);
    write_byte(8'h83, a); check(!a, "R1 ignored after mismatch", a, 0);
    write_byte(8'h55, a); check(!a, "R1 ignored after mismatch", a, 0);
    silent = 1'b0;
    bus_stop();
    byte_read(3, "R1 register untouched after mismatch");

    block_write(5, 8'h10);
    block_read(6, 1'b0);
    block_write(10, 8'h40);
    block_read(10, 1'b0);

    byte_write(12, 8'd3, "R5 set count");
    block_read(5, 1'b0);
    block_read(0, 1'b1);

    byte_write(12, 8'd20, "R8 raise count");
    block_read(18, 1'b0);

    repeat (20) @(posedge clk);
    finish_run();
  end
endmodule